// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt a small 8-bit core takes next. It has four source classes. A reset entry is raised by synchronous reset. A software trap arrives as a request pulse. A top-level hardware line reacts to a rising edge. A set of maskable lines each react to a rising edge on any of their pins. Each maskable line has its own enable and a 2-bit software priority. A 2-bit running level decides which maskable lines may preempt the code that is executing. A request that cannot be taken stays latched until it can be taken.

A winner is chosen first by software level and then by a fixed hardware order. It is reported as a registered vector index with a one-cycle acknowledge. Taking an interrupt raises the running level and saves the old level on a small internal stack. A return pulse restores the saved level. A direct level write lets software lower or raise the level. Register stacking, vector fetch and peripheral flags belong to the core and the peripherals, not to this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While `rst` is high and at the first clock edge after it is released, `cur_lvl` is 3 and nothing is pending except the reset entry. That first edge with `rst` low acknowledges the reset entry.
- R2: A maskable line is eligible only if its enable bit is 1 and its priority field (`src_prio[2i+1:2i]`) is strictly greater than `cur_lvl`. Priority 0 is therefore never taken, and level 3 blocks every maskable line.
- R3: A request that is not eligible stays pending. It is taken as soon as it becomes eligible, through an enable change or a lower level, with no new edge needed.
- R4: Among eligible requests the order is: reset first, then top-level line, then trap, then maskable lines. Maskable lines are ranked by priority, highest first. Between maskable lines of equal priority, the lower index wins.
- R5: Reset, trap and top-level requests are taken at any level. Each sets `cur_lvl` to 3.
- R6: A top-level request is taken while a trap routine runs at level 3.
- R7: A rising edge on any pin of a line latches that line. A pin held high does not latch the line again. The latch clears when the line is acknowledged.
- R8: Taking a maskable line sets `cur_lvl` to that line's priority. Taking a maskable, trap or top-level request pushes the previous level onto the stack.
- R9: A `ret_pulse` pops the stack into `cur_lvl`. The stack is 4 entries deep. A push onto a full stack discards the oldest entry. A pop from an empty stack gives level 3.
- R10: The vector code is 0 for reset, 1 for trap, 2 for top-level and 3+i for maskable line i. `irq_ack` is a single-cycle pulse. It appears at the clock edge that ends the decision cycle, together with `irq_vec` and the new level. At most one request is acknowledged per edge.
- R11: In a cycle with `lvl_wr` high, `cur_lvl` takes `lvl_wdata` and no request is taken. In a cycle with `ret_pulse` high and `lvl_wr` low, the stack is popped and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pins | input | N_SRC*PINS_PER_SRC | Maskable pins; the pins of line i are grouped and ORed |
| src_en | input | N_SRC | Enable for each maskable line |
| src_prio | input | 2*N_SRC | 2-bit priority for each maskable line |
| trap_req | input | 1 | Software trap request |
| tli_pin | input | 1 | Top-level hardware interrupt pin, rising edge |
| ret_pulse | input | 1 | Return from interrupt: pops the saved level |
| lvl_wr | input | 1 | Direct level write strobe |
| lvl_wdata | input | 2 | Level value to write |
| irq_ack | output | 1 | Acknowledge pulse |
| irq_vec | output | VEC_W | Vector code of the acknowledged request |
| cur_lvl | output | 2 | Running priority level |

## Verification
The hardest state to reach from the ports is a full stack that then overflows and drains back past the discarded entry. Only rising edges and trap pulses can push levels, and each push must arrive at a higher level or come from a request that ignores the level. The stimulus therefore climbs three maskable lines with priorities 1, 2 and 3, then adds a trap and a top-level edge for the fifth push. It then pops five times and expects the oldest level to be gone. A second hard case is a pending request that meets a return or a level write in the same cycle. The bench lines up the enable change with the return pulse so that arbitration is blocked at exactly that edge.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam logic [1:0] LVL_TOP = 2'b11;
  localparam int VEC_RST  = 0;
  localparam int VEC_TRAP = 1;
  localparam int VEC_TLI  = 2;
  localparam int VEC_SRC0 = 3;

  // a maskable line may preempt only when enabled and strictly above the level
  function automatic logic can_preempt(logic en, logic [1:0] prio, logic [1:0] lvl);
    return en && (prio > lvl);
  endfunction

  // level restored by a return: saved value, or the top level when nothing is saved
  function automatic logic [1:0] pop_level(logic has_entry, logic [1:0] top_entry);
    return has_entry ? top_entry : LVL_TOP;
  endfunction
endpackage

// File: rtl/nirq_edge_latch.sv
module nirq_edge_latch #(
  parameter int LINES = 4,
  parameter int PINS  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINES*PINS-1:0] pins,
  input  logic [LINES-1:0]      clr,
  output logic [LINES-1:0]      pend
);
  logic [LINES-1:0] line_or;
  logic [LINES-1:0] line_q;
  logic [LINES-1:0] rise;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_or[g] = |pins[g*PINS +: PINS];

    // R7: an edge always leaves the line pending on the next cycle
    p_edge_sets_r7: assert property (@(posedge clk) disable iff (rst)
      rise[g] |=> pend[g]);
    // R7: acknowledge clears the latch unless a fresh edge lands at once
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !rise[g]) |=> !pend[g]);
  end

  assign rise = line_or & ~line_q;

  always_ff @(posedge clk) begin
    line_q <= line_or;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | rise;
  end
endmodule

// File: rtl/nirq_lvl_stack.sv
module nirq_lvl_stack import nirq_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [1:0] new_lvl,
  input  logic       pop,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic [1:0] lvl
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       stk [DEPTH];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= LVL_TOP;
      cnt <= '0;
      for (int j = 0; j < DEPTH; j++) stk[j] <= LVL_TOP;
    end else if (wr) begin
      lvl <= wdata;
    end else if (pop) begin
      lvl <= pop_level(cnt != '0, stk[0]);
      for (int j = 0; j < DEPTH - 1; j++) stk[j] <= stk[j+1];
      stk[DEPTH-1] <= LVL_TOP;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end else if (push) begin
      lvl    <= new_lvl;
      stk[0] <= lvl;
      for (int j = 1; j < DEPTH; j++) stk[j] <= stk[j-1];
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end
  end

  // R9: the fill count never passes the depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  // R9: a return with nothing saved lands on the top level
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && !wr && cnt == '0) |=> lvl == LVL_TOP);
endmodule

// File: rtl/nirq_pick.sv
module nirq_pick import nirq_pkg::*; #(
  parameter int N_SRC = 4,
  parameter int VEC_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   pend_m,
  input  logic [N_SRC-1:0]   en_m,
  input  logic [2*N_SRC-1:0] prio_m,
  input  logic [1:0]         cur_lvl,
  input  logic               rst_pend,
  input  logic               tli_pend,
  input  logic               trap_pend,
  input  logic               hold,
  output logic               take,
  output logic               push,
  output logic [VEC_W-1:0]   vec,
  output logic [1:0]         next_lvl,
  output logic [N_SRC-1:0]   clr_m,
  output logic               clr_rst,
  output logic               clr_tli,
  output logic               clr_trap
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             best_ok;
  logic [IDX_W-1:0] best_idx;
  logic [1:0]       best_prio;

  // scan from the highest index down so that ties settle on the lowest index
  always_comb begin
    best_ok   = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_m[i] && can_preempt(en_m[i], prio_m[2*i +: 2], cur_lvl)
          && (!best_ok || prio_m[2*i +: 2] >= best_prio)) begin
        best_ok   = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio_m[2*i +: 2];
      end
    end
  end

  always_comb begin
    take     = 1'b0;
    push     = 1'b0;
    vec      = '0;
    next_lvl = cur_lvl;
    clr_m    = '0;
    clr_rst  = 1'b0;
    clr_tli  = 1'b0;
    clr_trap = 1'b0;
    if (!hold) begin
      if (rst_pend) begin
        take = 1'b1; vec = VEC_W'(VEC_RST); next_lvl = LVL_TOP; clr_rst = 1'b1;
      end else if (tli_pend) begin
        take = 1'b1; push = 1'b1; vec = VEC_W'(VEC_TLI); next_lvl = LVL_TOP; clr_tli = 1'b1;
      end else if (trap_pend) begin
        take = 1'b1; push = 1'b1; vec = VEC_W'(VEC_TRAP); next_lvl = LVL_TOP; clr_trap = 1'b1;
      end else if (best_ok) begin
        take = 1'b1; push = 1'b1;
        vec = VEC_W'(VEC_SRC0) + VEC_W'(best_idx);
        next_lvl = best_prio;
        clr_m[best_idx] = 1'b1;
      end
    end
  end

  // R10: one source at most is cleared per decision
  p_one_winner_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_rst, clr_tli, clr_trap, clr_m}));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl import nirq_pkg::*; #(
  parameter int N_SRC        = 4,
  parameter int PINS_PER_SRC = 2,
  parameter int STACK_DEPTH  = 4,
  localparam int VEC_W       = $clog2(N_SRC + VEC_SRC0)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC*PINS_PER_SRC-1:0] src_pins,
  input  logic [N_SRC-1:0]              src_en,
  input  logic [2*N_SRC-1:0]            src_prio,
  input  logic                          trap_req,
  input  logic                          tli_pin,
  input  logic                          ret_pulse,
  input  logic                          lvl_wr,
  input  logic [1:0]                    lvl_wdata,
  output logic                          irq_ack,
  output logic [VEC_W-1:0]              irq_vec,
  output logic [1:0]                    cur_lvl
);
  logic [N_SRC-1:0] pend_m, clr_m;
  logic             tli_pend, clr_tli;
  logic             trap_pend, clr_trap;
  logic             rst_pend, clr_rst;
  logic             take, push, hold;
  logic [VEC_W-1:0] win_vec;
  logic [1:0]       win_lvl;

  assign hold = ret_pulse | lvl_wr;

  nirq_edge_latch #(.LINES(N_SRC), .PINS(PINS_PER_SRC)) u_src_latch (
    .clk(clk), .rst(rst), .pins(src_pins), .clr(clr_m), .pend(pend_m));

  nirq_edge_latch #(.LINES(1), .PINS(1)) u_tli_latch (
    .clk(clk), .rst(rst), .pins(tli_pin), .clr(clr_tli), .pend(tli_pend));

  always_ff @(posedge clk) begin
    if (rst) trap_pend <= 1'b0;
    else     trap_pend <= (trap_pend & ~clr_trap) | trap_req;
  end

  always_ff @(posedge clk) begin
    if (rst)          rst_pend <= 1'b1;
    else if (clr_rst) rst_pend <= 1'b0;
  end

  nirq_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
    .clk(clk), .rst(rst), .pend_m(pend_m), .en_m(src_en), .prio_m(src_prio),
    .cur_lvl(cur_lvl), .rst_pend(rst_pend), .tli_pend(tli_pend), .trap_pend(trap_pend),
    .hold(hold), .take(take), .push(push), .vec(win_vec), .next_lvl(win_lvl),
    .clr_m(clr_m), .clr_rst(clr_rst), .clr_tli(clr_tli), .clr_trap(clr_trap));

  nirq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .new_lvl(win_lvl), .pop(ret_pulse),
    .wr(lvl_wr), .wdata(lvl_wdata), .lvl(cur_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ack <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_ack <= take;
      if (take) irq_vec <= win_vec;
    end
  end

  // R5: non-maskable entries always land on the top level
  p_nmi_top_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_vec < VEC_W'(VEC_SRC0)) |-> cur_lvl == LVL_TOP);
  // R8: a maskable entry always raises the level above the one it preempted
  p_mask_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_vec >= VEC_W'(VEC_SRC0)) |-> cur_lvl > $past(cur_lvl));
  // R11: a return or level write blocks the decision of its cycle
  p_hold_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> !irq_ack);
  // R10: the vector code is always a defined one
  p_vec_range_r10: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> irq_vec < VEC_W'(N_SRC + VEC_SRC0));
endmodule

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_pins = '0;
  logic [3:0] src_en = '0;
  logic [7:0] src_prio = '0;
  logic       trap_req = 1'b0;
  logic       tli_pin = 1'b0;
  logic       ret_pulse = 1'b0;
  logic       lvl_wr = 1'b0;
  logic [1:0] lvl_wdata = '0;
  logic       irq_ack;
  logic [2:0] irq_vec;
  logic [1:0] cur_lvl;

  int  total = 0;
  int  bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  nest_irq_ctrl uut (
    .clk(clk), .rst(rst), .src_pins(src_pins), .src_en(src_en), .src_prio(src_prio),
    .trap_req(trap_req), .tli_pin(tli_pin), .ret_pulse(ret_pulse), .lvl_wr(lvl_wr),
    .lvl_wdata(lvl_wdata), .irq_ack(irq_ack), .irq_vec(irq_vec), .cur_lvl(cur_lvl));

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] lvl;
    logic [3:0] en;
    logic [7:0] prio;
    logic [7:0] pins;
    logic       trap;
    logic       tli;
    logic       ack;
    logic [2:0] vec;
    logic [1:0] nlvl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{4'd7, 2'd0, 4'hF, 8'b01010101, 8'b00000010, 1'b0, 1'b0, 1'b1, 3'd3, 2'd1}, // R7 second pin of line 0
    '{4'd4, 2'd0, 4'hF, 8'b00110001, 8'b00010001, 1'b0, 1'b0, 1'b1, 3'd5, 2'd3}, // R4 higher level wins
    '{4'd4, 2'd1, 4'hF, 8'b10001000, 8'b01000100, 1'b0, 1'b0, 1'b1, 3'd4, 2'd2}, // R4 tie, low index
    '{4'd2, 2'd2, 4'hF, 8'b00001011, 8'b00000101, 1'b0, 1'b0, 1'b1, 3'd3, 2'd3}, // R2 only prio above level
    '{4'd5, 2'd0, 4'hF, 8'b00000011, 8'b00000001, 1'b1, 1'b0, 1'b1, 3'd1, 2'd3}, // R5 trap over maskable
    '{4'd4, 2'd3, 4'hF, 8'b00000000, 8'b00000000, 1'b1, 1'b1, 1'b1, 3'd2, 2'd3}, // R4 top-level over trap
    '{4'd2, 2'd0, 4'b1101, 8'b00011100, 8'b00010100, 1'b0, 1'b0, 1'b1, 3'd5, 2'd1}, // R2 disabled skipped
    '{4'd2, 2'd0, 4'hF, 8'b00000000, 8'b00000011, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0}, // R2 priority zero
    '{4'd2, 2'd3, 4'hF, 8'b11111111, 8'b11111111, 1'b0, 1'b0, 1'b0, 3'd0, 2'd3}, // R2 level three blocks
    '{4'd2, 2'd2, 4'hF, 8'b10101010, 8'b01010101, 1'b0, 1'b0, 1'b0, 3'd0, 2'd2}  // R2 strictly greater
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick();
    rst = 1'b1; src_pins = '0; src_en = '0; src_prio = '0;
    trap_req = 1'b0; tli_pin = 1'b0; ret_pulse = 1'b0; lvl_wr = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
    tick(); // reset entry acknowledged here
    tick();
  endtask

  task automatic set_level(logic [1:0] l);
    lvl_wr = 1'b1; lvl_wdata = l;
    tick();
    lvl_wr = 1'b0;
  endtask

  task automatic pop_and_check(int exp_lvl);
    ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
    check("R9 pop level", cur_lvl, exp_lvl);
  endtask

  task automatic fire_pins(logic [7:0] p, int exp_vec, int exp_lvl);
    src_pins = p;
    repeat (2) tick();
    check("R8 ack", irq_ack, 1);
    check("R10 vector", irq_vec, exp_vec);
    check("R8 level", cur_lvl, exp_lvl);
    src_pins = '0;
  endtask

  initial begin
    // R1 / R10: reset state and the reset entry
    repeat (3) tick();
    check("R1 level in reset", cur_lvl, 3);
    check("R1 no ack in reset", irq_ack, 0);
    rst = 1'b0;
    tick();
    check("R1 reset entry ack", irq_ack, 1);
    check("R10 reset vector", irq_vec, 0);
    check("R1 level after reset", cur_lvl, 3);
    tick();
    check("R10 single pulse", irq_ack, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      do_reset();
      src_en = TBL[k].en; src_prio = TBL[k].prio;
      set_level(TBL[k].lvl);
      src_pins = TBL[k].pins; trap_req = TBL[k].trap; tli_pin = TBL[k].tli;
      tick();
      trap_req = 1'b0;
      tick();
      total++;
      if (irq_ack !== TBL[k].ack || (TBL[k].ack && irq_vec !== TBL[k].vec)
          || cur_lvl !== TBL[k].nlvl) begin
        bad++;
        $display("FAIL R%0d entry %0d: actual ack=%0d vec=%0d lvl=%0d expected ack=%0d vec=%0d lvl=%0d",
                 TBL[k].req, k, irq_ack, irq_vec, cur_lvl, TBL[k].ack, TBL[k].vec, TBL[k].nlvl);
      end
      src_pins = '0; tli_pin = 1'b0; src_en = '0;
    end

    // R3 / R7: pending survives a disabled period, held pin does not retrigger
    do_reset();
    src_prio = 8'b00000010;
    set_level(2'd0);
    src_pins = 8'b00000001;
    repeat (4) tick();
    check("R3 disabled stays quiet", irq_ack, 0);
    src_en = 4'b0001;
    tick();
    check("R3 taken after enable", irq_ack, 1);
    check("R3 vector", irq_vec, 3);
    check("R3 level", cur_lvl, 2);
    set_level(2'd0);
    repeat (3) tick();
    check("R7 held pin no retrigger", irq_ack, 0);
    src_pins = 8'b00000000;
    tick();
    src_pins = 8'b00000010;
    repeat (2) tick();
    check("R7 other pin of line", irq_ack, 1);
    check("R7 vector", irq_vec, 3);
    src_pins = '0; src_en = '0;

    // R6 / R9: top-level preempts trap, returns unwind
    do_reset();
    set_level(2'd0);
    trap_req = 1'b1;
    tick();
    trap_req = 1'b0;
    tick();
    check("R5 trap vector", irq_vec, 1);
    check("R5 trap level", cur_lvl, 3);
    tli_pin = 1'b1;
    repeat (2) tick();
    check("R6 top-level ack", irq_ack, 1);
    check("R6 top-level vector", irq_vec, 2);
    tli_pin = 1'b0;
    pop_and_check(3);
    pop_and_check(0);

    // R8 / R9: five nested entries on a four-deep stack
    do_reset();
    src_en = 4'hF; src_prio = 8'b00111001;
    set_level(2'd0);
    fire_pins(8'b00000001, 3, 1);
    fire_pins(8'b00000100, 4, 2);
    fire_pins(8'b00010000, 5, 3);
    trap_req = 1'b1;
    tick();
    trap_req = 1'b0;
    tick();
    check("R5 nested trap", irq_vec, 1);
    tli_pin = 1'b1;
    repeat (2) tick();
    check("R6 nested top-level", irq_vec, 2);
    tli_pin = 1'b0;
    pop_and_check(3);
    pop_and_check(3);
    pop_and_check(2);
    pop_and_check(1);
    pop_and_check(3); // oldest saved 0 was discarded

    // R11: return and level write block arbitration in their cycle
    do_reset();
    src_prio = 8'b00000010;
    set_level(2'd0);
    src_pins = 8'b00000001;
    repeat (2) tick();
    src_pins = '0;
    src_en = 4'b0001; ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
    check("R11 no take on return", irq_ack, 0);
    check("R9 empty pop level", cur_lvl, 3);
    tick();
    check("R2 blocked at level 3", irq_ack, 0);
    lvl_wr = 1'b1; lvl_wdata = 2'd0;
    tick();
    lvl_wr = 1'b0;
    check("R11 no take on write", irq_ack, 0);
    check("R11 level written", cur_lvl, 0);
    tick();
    check("R3 taken after write", irq_ack, 1);
    check("R3 level", cur_lvl, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule